// File: doc/BRIEF.md
# Memory-Mapped SPI Transfer Queue

This block sits between a CPU-style memory bus and a serial engine that does the actual SPI shifting. Software sends a transfer by writing a word into a 4 KB transmit window. The word offset of that write picks one of up to eight peripheral slots, and the payload is queued together with its slot tag. Received words collect in a second queue. Software drains that queue by reading from a separate 4 KB receive window. Byte, halfword and word stores are all accepted as payloads. A narrow store is kept right-aligned with its upper bits cleared.

A small register block holds the controls for each direction (an enable bit and a stored threshold field) and a status word for each direction (busy, empty, full and fill level). It also holds a global engine enable and a two-bit event unit with pending and enable registers, which drives a level interrupt. When the transmit queue is full, the bus write is held off until space opens. The write is never dropped. The serial engine takes words through a ready/valid pair that carries data plus slot id, and it returns words through a second ready/valid pair.

Top module: `spixq_top`

## Requirements
- R1: Address bits 13:12 select the region: 0 is the register block, 1 is the transmit window, 2 is the receive window. In the register block the byte offsets are: 0x00 transmit control, 0x04 transmit status, 0x08 receive control, 0x0C receive status, 0x10 engine control, 0x14 event pending, 0x18 event enable. Other offsets read zero. Reading the transmit window returns zero. Writing the receive window changes nothing.
- R2: A write to the transmit window queues one entry. The entry's slot is address bits 4:2. Its payload is the write data right-aligned to `bus_size` (0 = byte, 1 = halfword, 2 or 3 = word), with the bits above the access width cleared.
- R3: When the transmit queue holds 32 entries, a transmit write gets no acknowledge. It completes once the engine has taken an entry.
- R4: A read of the receive window returns the oldest received word and removes it. A read while the queue is empty is acknowledged with zero.
- R5: Each status word reads as follows: bit 0 is `eng_busy`, bit 1 is queue empty, bit 2 is queue full, and bits 31:16 are the fill level. All other bits are zero.
- R6: Each control register keeps its enable in bit 0 and a 16-bit threshold in bits 31:16, and reads back what was written. The engine control register keeps its enable in bit 0.
- R7: `eng_tx_valid` is high only when the engine enable and the transmit enable are both set and the transmit queue is not empty. `eng_rx_ready` is high only when the engine enable and the receive enable are both set and the receive queue is not full. Both queues keep first-in first-out order.
- R8: Pending bit 0 is set when the engine takes a transmit word. Pending bit 1 is set when a word enters the receive queue. Writing 1 to a pending bit clears it. A set in the same cycle as a clear wins.
- R9: `irq` is high whenever some pending bit has its enable bit set.
- R10: A request is acknowledged by a one-cycle `bus_ack` pulse in the cycle after it is accepted. Read data is valid during that pulse.
- R11: After reset, both queues are empty, all control, enable and pending bits are zero, and `bus_ack` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address (region in bits 13:12) |
| bus_size | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid with acknowledge |
| eng_tx_valid | output | 1 | Transmit word offered to engine |
| eng_tx_ready | input | 1 | Engine takes the offered word |
| eng_tx_data | output | 32 | Transmit payload |
| eng_tx_slot | output | SLOT_W | Target slot of the payload |
| eng_rx_valid | input | 1 | Engine presents a received word |
| eng_rx_ready | output | 1 | Receive queue accepts the word |
| eng_rx_data | input | 32 | Received word |
| eng_busy | input | 1 | Engine is shifting a transfer |
| irq | output | 1 | Interrupt request |

## Verification
The acknowledge and its read data appear one edge after the request is accepted, so the bench samples each reply at the falling edge after that. Queue heads, `eng_tx_valid`, `eng_rx_ready` and `irq` all reflect an edge's pushes, pops and register writes at the following falling edge. The bench model advances its queues and registers at every rising edge from the same sampled inputs and compares all these outputs at each falling edge. Held-off writes are checked by watching, cycle by cycle, that no acknowledge appears while the queue is full.

// File: rtl/spixq_pkg.sv
package spixq_pkg;

    localparam int BUS_W       = 32;
    localparam int ADDR_W      = 14;
    localparam int WIN_LSB     = 12;
    localparam int LVL_FIELD_W = 16;
    localparam int NUM_EV      = 2;
    localparam int EV_TX       = 0;
    localparam int EV_RX       = 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        RG_REGS = 2'd0,
        RG_TX   = 2'd1,
        RG_RX   = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        SEL_TXCTL  = 3'd0,
        SEL_TXSTAT = 3'd1,
        SEL_RXCTL  = 3'd2,
        SEL_RXSTAT = 3'd3,
        SEL_ENG    = 3'd4,
        SEL_PEND   = 3'd5,
        SEL_ENA    = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [LVL_FIELD_W-1:0] thr;
        logic                   en;
    } dir_ctl_t;

    function automatic logic [BUS_W-1:0] align_payload(logic [BUS_W-1:0] d, xfer_size_e s);
        case (s)
            SZ_BYTE: align_payload = {{(BUS_W-8){1'b0}},  d[7:0]};
            SZ_HALF: align_payload = {{(BUS_W-16){1'b0}}, d[15:0]};
            default: align_payload = d;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] pack_status(logic [LVL_FIELD_W-1:0] lvl,
                                                     logic full, logic empty, logic busy);
        pack_status = '0;
        pack_status[BUS_W-1 -: LVL_FIELD_W] = lvl;
        pack_status[2] = full;
        pack_status[1] = empty;
        pack_status[0] = busy;
    endfunction

    function automatic logic [BUS_W-1:0] pack_ctl(dir_ctl_t c);
        pack_ctl = '0;
        pack_ctl[BUS_W-1 -: LVL_FIELD_W] = c.thr;
        pack_ctl[0] = c.en;
    endfunction

endpackage

// File: rtl/spixq_fifo.sv
module spixq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [LVL_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        bump = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == LVL_W'(DEPTH));
    assign level = cnt;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
    assert_level_bound_R5: assert property (@(posedge clk) disable iff (rst) level <= LVL_W'(DEPTH));

endmodule

// File: rtl/spixq_decode.sv
module spixq_decode
    import spixq_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output reg_sel_e          sel,
    output logic [SLOT_W-1:0] slot
);
    localparam int IDX_W = WIN_LSB - 2;
    localparam int NREGS = 7;

    logic [IDX_W-1:0] idx;
    logic             unused_lsb;

    assign idx        = addr[WIN_LSB-1:2];
    assign region     = region_e'(addr[WIN_LSB+1:WIN_LSB]);
    assign slot       = addr[2 +: SLOT_W];
    assign unused_lsb = ^addr[1:0];

    always_comb begin
        if (idx < IDX_W'(NREGS)) sel = reg_sel_e'(idx[2:0]);
        else                     sel = SEL_NONE;
    end

endmodule

// File: rtl/spixq_events.sv
module spixq_events
    import spixq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] ev_set,
    input  logic              clr_we,
    input  logic [NUM_EV-1:0] clr_mask,
    input  logic              ena_we,
    input  logic [NUM_EV-1:0] ena_din,
    output logic [NUM_EV-1:0] pend,
    output logic [NUM_EV-1:0] ena,
    output logic              irq
);
    logic [NUM_EV-1:0] clr_eff;
    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            ena  <= '0;
        end else begin
            pend <= ev_set | (pend & ~clr_eff);
            if (ena_we) ena <= ena_din;
        end
    end

    assign irq = |(pend & ena);

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev_chk
        assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
            ev_set[i] |=> pend[i]);
        assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
            (clr_we && clr_mask[i] && !ev_set[i]) |=> !pend[i]);
    end

endmodule

// File: rtl/spixq_top.sv
module spixq_top
    import spixq_pkg::*;
#(
    parameter int SLOT_W   = 3,
    parameter int TX_DEPTH = 32,
    parameter int RX_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [13:0]       bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ack,
    output logic [31:0]       bus_rdata,
    output logic              eng_tx_valid,
    input  logic              eng_tx_ready,
    output logic [31:0]       eng_tx_data,
    output logic [SLOT_W-1:0] eng_tx_slot,
    input  logic              eng_rx_valid,
    output logic              eng_rx_ready,
    input  logic [31:0]       eng_rx_data,
    input  logic              eng_busy,
    output logic              irq
);
    localparam int TXW   = SLOT_W + BUS_W;
    localparam int TXL_W = $clog2(TX_DEPTH + 1);
    localparam int RXL_W = $clog2(RX_DEPTH + 1);

    region_e           region;
    reg_sel_e          sel;
    logic [SLOT_W-1:0] slot;

    spixq_decode #(.SLOT_W(SLOT_W)) u_dec (
        .addr(bus_addr), .region(region), .sel(sel), .slot(slot)
    );

    // control state
    dir_ctl_t tx_ctl, rx_ctl;
    logic     eng_en;
    logic     ack_q;
    logic [BUS_W-1:0] rdata_q;

    // queues
    logic             tx_push, tx_pop, tx_empty, tx_full;
    logic [TXW-1:0]   tx_din, tx_dout;
    logic [TXL_W-1:0] tx_level;
    logic             rx_push, rx_pop, rx_empty, rx_full;
    logic [BUS_W-1:0] rx_dout;
    logic [RXL_W-1:0] rx_level;

    // bus handling
    logic             open_req, tx_blocked, accept, rx_rd, reg_wr;
    logic [BUS_W-1:0] wpay, rd_val;

    always_comb begin
        open_req   = bus_req && !ack_q;
        tx_blocked = bus_we && (region == RG_TX) && tx_full;
        accept     = open_req && !tx_blocked;
        wpay       = align_payload(bus_wdata, xfer_size_e'(bus_size));
        tx_push    = accept && bus_we && (region == RG_TX);
        rx_rd      = accept && !bus_we && (region == RG_RX);
        rx_pop     = rx_rd && !rx_empty;
        reg_wr     = accept && bus_we && (region == RG_REGS);
        tx_din     = {slot, wpay};
    end

    // engine side
    assign eng_tx_valid = eng_en && tx_ctl.en && !tx_empty;
    assign tx_pop       = eng_tx_valid && eng_tx_ready;
    assign eng_tx_slot  = tx_dout[TXW-1 -: SLOT_W];
    assign eng_tx_data  = tx_dout[BUS_W-1:0];
    assign eng_rx_ready = eng_en && rx_ctl.en && !rx_full;
    assign rx_push      = eng_rx_valid && eng_rx_ready;

    spixq_fifo #(.W(TXW), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .din(tx_din), .pop(tx_pop),
        .dout(tx_dout), .empty(tx_empty), .full(tx_full), .level(tx_level)
    );

    spixq_fifo #(.W(BUS_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .din(eng_rx_data), .pop(rx_pop),
        .dout(rx_dout), .empty(rx_empty), .full(rx_full), .level(rx_level)
    );

    // events
    logic [NUM_EV-1:0] ev_set, pend, ena;
    always_comb begin
        ev_set        = '0;
        ev_set[EV_TX] = tx_pop;
        ev_set[EV_RX] = rx_push;
    end

    spixq_events u_ev (
        .clk(clk), .rst(rst), .ev_set(ev_set),
        .clr_we(reg_wr && sel == SEL_PEND), .clr_mask(wpay[NUM_EV-1:0]),
        .ena_we(reg_wr && sel == SEL_ENA),  .ena_din(wpay[NUM_EV-1:0]),
        .pend(pend), .ena(ena), .irq(irq)
    );

    // read mux
    always_comb begin
        rd_val = '0;
        case (region)
            RG_RX: rd_val = rx_empty ? '0 : rx_dout;
            RG_REGS: begin
                case (sel)
                    SEL_TXCTL:  rd_val = pack_ctl(tx_ctl);
                    SEL_TXSTAT: rd_val = pack_status(LVL_FIELD_W'(tx_level), tx_full, tx_empty, eng_busy);
                    SEL_RXCTL:  rd_val = pack_ctl(rx_ctl);
                    SEL_RXSTAT: rd_val = pack_status(LVL_FIELD_W'(rx_level), rx_full, rx_empty, eng_busy);
                    SEL_ENG:    rd_val = {{(BUS_W-1){1'b0}}, eng_en};
                    SEL_PEND:   rd_val = {{(BUS_W-NUM_EV){1'b0}}, pend};
                    SEL_ENA:    rd_val = {{(BUS_W-NUM_EV){1'b0}}, ena};
                    default:    rd_val = '0;
                endcase
            end
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
            tx_ctl  <= '0;
            rx_ctl  <= '0;
            eng_en  <= 1'b0;
        end else begin
            ack_q <= accept;
            if (accept) rdata_q <= bus_we ? '0 : rd_val;
            if (reg_wr) begin
                case (sel)
                    SEL_TXCTL: tx_ctl <= '{thr: wpay[BUS_W-1 -: LVL_FIELD_W], en: wpay[0]};
                    SEL_RXCTL: rx_ctl <= '{thr: wpay[BUS_W-1 -: LVL_FIELD_W], en: wpay[0]};
                    SEL_ENG:   eng_en <= wpay[0];
                    default: ;
                endcase
            end
        end
    end

    assign bus_ack   = ack_q;
    assign bus_rdata = rdata_q;

    assert_stall_full_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack && bus_we && region == RG_TX && tx_full) |=> !bus_ack);
    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);
    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (eng_tx_valid && !eng_tx_ready && !reg_wr) |=>
        (eng_tx_valid && $stable(eng_tx_data) && $stable(eng_tx_slot)));
    assert_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && rx_empty) |=> (bus_ack && bus_rdata == '0));

endmodule

// File: tb/spixq_top_tb_top.sv
module spixq_top_tb_top;
    localparam int SW = 3;
    localparam int QD = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          bus_req = 0, bus_we = 0;
    logic [13:0]   bus_addr = '0;
    logic [1:0]    bus_size = 2'd2;
    logic [31:0]   bus_wdata = '0;
    logic          bus_ack;
    logic [31:0]   bus_rdata;
    logic          eng_tx_valid, eng_tx_ready = 0;
    logic [31:0]   eng_tx_data;
    logic [SW-1:0] eng_tx_slot;
    logic          eng_rx_valid = 0, eng_rx_ready;
    logic [31:0]   eng_rx_data = '0;
    logic          eng_busy = 0;
    logic          irq;

    spixq_top #(.SLOT_W(SW), .TX_DEPTH(QD), .RX_DEPTH(QD)) dut_i (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data),
        .eng_tx_slot(eng_tx_slot), .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready),
        .eng_rx_data(eng_rx_data), .eng_busy(eng_busy), .irq(irq)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [34:0] m_txq[$];
    logic [31:0] m_rxq[$];
    logic        m_txen, m_rxen, m_eng, m_ack;
    logic [15:0] m_txthr, m_rxthr;
    logic [1:0]  m_pend, m_ena;
    logic [31:0] m_rdata;

    function automatic logic [31:0] m_align(logic [31:0] d, logic [1:0] s);
        if (s == 2'd0) return {24'b0, d[7:0]};
        if (s == 2'd1) return {16'b0, d[15:0]};
        return d;
    endfunction

    function automatic logic [31:0] m_stat(int lvl, logic busy);
        return {16'(lvl), 13'b0, lvl == QD, lvl == 0, busy};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_txq.delete(); m_rxq.delete();
            m_txen = 0; m_rxen = 0; m_eng = 0; m_ack = 0;
            m_txthr = 0; m_rxthr = 0; m_pend = 0; m_ena = 0; m_rdata = 0;
        end else begin
            logic txv, rxr, take, put, acc;
            logic [1:0]  rg;
            int          idx;
            logic [31:0] rd, w;
            logic [1:0]  clr;
            txv  = m_eng && m_txen && (m_txq.size() > 0);
            rxr  = m_eng && m_rxen && (m_rxq.size() < QD);
            take = txv && eng_tx_ready;
            put  = rxr && eng_rx_valid;
            rg   = bus_addr[13:12];
            idx  = int'(bus_addr[11:2]);
            acc  = bus_req && !m_ack && !(bus_we && rg == 2'd1 && m_txq.size() == QD);
            w    = m_align(bus_wdata, bus_size);
            rd   = 0;
            clr  = 0;
            if (acc && !bus_we) begin
                if (rg == 2'd2 && m_rxq.size() > 0) rd = m_rxq[0];
                if (rg == 2'd0) begin
                    case (idx)
                        0: rd = {m_txthr, 15'b0, m_txen};
                        1: rd = m_stat(m_txq.size(), eng_busy);
                        2: rd = {m_rxthr, 15'b0, m_rxen};
                        3: rd = m_stat(m_rxq.size(), eng_busy);
                        4: rd = {31'b0, m_eng};
                        5: rd = {30'b0, m_pend};
                        6: rd = {30'b0, m_ena};
                        default: rd = 0;
                    endcase
                end
            end
            if (take) void'(m_txq.pop_front());
            if (acc && !bus_we && rg == 2'd2 && m_rxq.size() > 0) void'(m_rxq.pop_front());
            if (acc && bus_we && rg == 2'd1) m_txq.push_back({bus_addr[4:2], w});
            if (put) m_rxq.push_back(eng_rx_data);
            if (acc && bus_we && rg == 2'd0) begin
                case (idx)
                    0: begin m_txen = w[0]; m_txthr = w[31:16]; end
                    2: begin m_rxen = w[0]; m_rxthr = w[31:16]; end
                    4: m_eng = w[0];
                    5: clr = w[1:0];
                    6: m_ena = w[1:0];
                    default: ;
                endcase
            end
            m_pend = (m_pend & ~clr) | {put, take};
            m_ack  = acc;
            if (acc) m_rdata = rd;
        end
    end

    // per-cycle compare
    always @(negedge clk) begin
        if (!rst) begin
            logic ev;
            ev = m_eng && m_txen && (m_txq.size() > 0);
            chk("R10", "bus_ack", 32'(bus_ack), 32'(m_ack));
            if (m_ack) chk("R10", "bus_rdata", bus_rdata, m_rdata);
            chk("R7", "eng_tx_valid", 32'(eng_tx_valid), 32'(ev));
            if (ev) chk("R2", "tx head", {eng_tx_slot, eng_tx_data[28:0]},
                        {m_txq[0][34:32], m_txq[0][28:0]});
            if (ev) chk("R2", "tx data", eng_tx_data, m_txq[0][31:0]);
            chk("R7", "eng_rx_ready", 32'(eng_rx_ready),
                32'(m_eng && m_rxen && (m_rxq.size() < QD)));
            chk("R9", "irq", 32'(irq), 32'(|(m_pend & m_ena)));
        end
    end

    // ---------------- loopback engine stub ----------------
    logic        eng_stall = 0, hold = 0, tx_hs = 0, rx_hs = 0;
    logic [31:0] cap = 0, buf_w = 0;
    int          cnt = 0;

    always @(negedge clk) begin
        if (rst) begin
            hold = 0; eng_rx_valid = 0; eng_tx_ready = 0; tx_hs = 0; rx_hs = 0; eng_busy = 0;
        end else begin
            if (rx_hs) begin hold = 0; eng_rx_valid = 0; end
            if (tx_hs) begin hold = 1; cnt = 6; buf_w = cap; end
            if (hold && !eng_rx_valid) begin
                if (cnt == 0) begin eng_rx_valid = 1; eng_rx_data = buf_w; end
                else cnt--;
            end
            eng_tx_ready = !hold && !eng_stall;
            eng_busy     = hold;
            tx_hs = eng_tx_valid && eng_tx_ready;
            cap   = eng_tx_data;
            rx_hs = eng_rx_valid && eng_rx_ready;
        end
    end

    // ---------------- stimulus ----------------
    task automatic xfer(input logic we, input logic [13:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_req = 1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
        do @(negedge clk); while (!bus_ack);
        rd = bus_rdata;
        bus_req = 0;
    endtask

    task automatic wr(input logic [13:0] a, input logic [1:0] sz, input logic [31:0] wd);
        logic [31:0] dummy;
        xfer(1'b1, a, sz, wd, dummy);
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        xfer(1'b0, a, 2'd2, 32'h0, d);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got cycle %0d expected completion", cyc);
            summary();
            $finish;
        end
    end

    localparam logic [13:0] A_TXC = 14'h0000, A_TXS = 14'h0004, A_RXC = 14'h0008,
                            A_RXS = 14'h000C, A_ENG = 14'h0010, A_PND = 14'h0014,
                            A_ENA = 14'h0018, TXW = 14'h1000, RXW = 14'h2000;

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst = 0;

        // R11 reset state
        @(negedge clk);
        chk("R11", "irq after reset", 32'(irq), 0);
        rd(A_TXS, d); chk("R11", "tx status", d, 32'h0000_0002);
        rd(A_RXS, d); chk("R11", "rx status", d, 32'h0000_0002);
        rd(A_ENG, d); chk("R11", "engine ctl", d, 0);
        rd(A_PND, d); chk("R11", "pending", d, 0);

        // R1 region map corners
        rd(TXW, d); chk("R1", "tx window read", d, 0);
        wr(RXW, 2'd2, 32'h1234_5678);
        rd(A_RXS, d); chk("R1", "rx window write ignored", d, 32'h0000_0002);
        rd(14'h001C, d); chk("R1", "unmapped reg", d, 0);

        // R6 control readback
        wr(A_TXC, 2'd2, 32'h0007_0001);
        wr(A_RXC, 2'd2, 32'h0009_0001);
        rd(A_TXC, d); chk("R6", "tx ctl", d, 32'h0007_0001);
        rd(A_RXC, d); chk("R6", "rx ctl", d, 32'h0009_0001);
        wr(A_ENG, 2'd2, 32'h1);
        rd(A_ENG, d); chk("R6", "engine ctl", d, 32'h1);

        // R2 sizes and slots, R4 order
        wr(TXW + 14'h0,  2'd0, 32'hDEAD_BE5A);
        wr(TXW + 14'h4,  2'd1, 32'h1234_5AA5);
        wr(TXW + 14'h8,  2'd2, 32'h0102_0304);
        wr(TXW + 14'h1C, 2'd0, 32'hFFFF_FF01);
        repeat (60) @(negedge clk);
        rd(RXW, d); chk("R2", "byte payload", d, 32'h0000_005A);
        rd(RXW, d); chk("R2", "half payload", d, 32'h0000_5AA5);
        rd(RXW, d); chk("R4", "word payload", d, 32'h0102_0304);
        rd(RXW, d); chk("R2", "slot7 byte", d, 32'h0000_0001);
        rd(RXW, d); chk("R4", "empty read", d, 0);

        // R3 and R5: fill the transmit queue with engine stalled
        eng_stall = 1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < QD; i++) wr(TXW + 14'(4 * (i % 8)), 2'd2, 32'hC0DE_0000 + i);
        rd(A_TXS, d); chk("R5", "tx full status", d, 32'h0020_0004);
        fork
            wr(TXW + 14'(4 * (QD % 8)), 2'd2, 32'hC0DE_0000 + QD);
            begin
                repeat (20) @(negedge clk);
                chk("R3", "no ack while full", 32'(bus_ack), 0);
                eng_stall = 0;
            end
        join
        repeat (450) @(negedge clk);
        rd(A_RXS, d); chk("R5", "rx full status", d, 32'h0020_0005);
        for (int i = 0; i <= QD; i++) begin
            rd(RXW, d); chk("R4", "rx order", d, 32'hC0DE_0000 + i);
        end
        repeat (20) @(negedge clk);
        rd(A_RXS, d); chk("R5", "rx drained", d, 32'h0000_0002);
        rd(A_TXS, d); chk("R5", "tx drained", d, 32'h0000_0002);

        // R7 gating by engine enable
        wr(A_ENG, 2'd2, 32'h0);
        wr(TXW, 2'd2, 32'hABCD_0001);
        repeat (30) @(negedge clk);
        rd(A_TXS, d); chk("R7", "held while disabled", d, 32'h0001_0000);
        wr(A_ENG, 2'd2, 32'h1);
        repeat (30) @(negedge clk);
        rd(RXW, d); chk("R7", "released word", d, 32'hABCD_0001);

        // R8 / R9 events
        wr(A_PND, 2'd2, 32'h3);
        rd(A_PND, d); chk("R8", "pending cleared", d, 0);
        wr(A_ENA, 2'd2, 32'h3);
        wr(TXW, 2'd2, 32'h0000_0001);
        repeat (40) @(negedge clk);
        rd(A_PND, d); chk("R8", "both pending", d, 32'h3);
        @(negedge clk); chk("R9", "irq raised", 32'(irq), 1);
        wr(A_PND, 2'd2, 32'h1);
        rd(A_PND, d); chk("R8", "tx cleared only", d, 32'h2);
        rd(RXW, d); chk("R4", "event word", d, 32'h1);
        wr(A_PND, 2'd2, 32'h2);
        rd(A_PND, d); chk("R8", "all cleared", d, 0);
        @(negedge clk); chk("R9", "irq dropped", 32'(irq), 0);
        wr(A_ENA, 2'd0, 32'h0);

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

endmodule